// File: doc/BRIEF.md
# Channel-Associated Signaling Receive Change Monitor

This block sits on the receive side of a 30-channel framed trunk. Each frame it takes in the timeslot-16 byte together with that frame's position (0 to 15) inside the signaling multiframe. It splits the byte into two 4-bit ABCD signaling nibbles and files each one under its channel in a 30-entry store that a control read port can reach. It also passes the byte, with its frame number, out on a serial-side stream. Both destinations are updated for every frame that carries channel data.

When a stored value is replaced by a different one, the block notes a pending signaling change. Channels flagged as clear channels are left out of this. Changes from all channels merge into a single sticky status bit. That bit is set only once a selectable hold-off timer, which counts 125 µs frame ticks, has run out. Reading the status (a one-cycle pulse) clears it and restarts the timer, so at most one interrupt fires per hold-off period however many channels changed. The interrupt line is the status bit gated by an active-high mask.

Both streams use valid/ready. A beat moves on a clock edge where valid and ready are both high. Once out_valid is raised, the sender holds the beat stable until out_ready accepts it. The input accepts a byte whenever the output register is empty or is being drained in the same cycle, so a stalled output stalls the input.

Top module: `cas_sig_monitor`

## Requirements
- R1: A byte accepted with frame index f in 1..15 puts bits [7:4] into channel f and bits [3:0] into channel f+15. A byte accepted with frame index 0 changes no channel and produces no output beat.
- R2: Every accepted byte with frame 1..15 is written to the store, readable at rd_abcd for rd_chan = channel number (1..30) in the cycle after acceptance. The same byte and its frame index also appear as one beat on sig_byte/sig_frame.
- R3: While sig_valid is high and sig_ready is low, sig_frame and sig_byte hold steady and ts16_ready is low. A byte offered during the stall is not taken and does not alter the store.
- R4: After reset, no change is flagged until a frame-0 byte has been accepted and then a frame-15 byte has completed that multiframe. Values received before then are still stored.
- R5: After that first multiframe, a nibble that differs from the stored value of a non-clear channel produces a pending change. A byte equal to the stored values produces none.
- R6: A channel i (1..30) whose clear_chan bit i-1 is 1 never creates a pending change, but its value is still stored and forwarded.
- R7: hold_sel picks the hold-off period in frame ticks: 00 = 16, 01 = 64, 10 = 128, 11 = 128. The timer starts at reset and restarts on each status_rd pulse. chg_status is set only when a change is pending and that many ticks have been counted.
- R8: chg_status stays set until status_rd. It can rise at most once per hold-off period. Any number of changes within one period give one status assertion, and a change seen while status is set raises status again only after the next full period.
- R9: irq is high exactly when chg_status is 1 and irq_mask is 0. chg_status still sets while the mask is 1.
- R10: After reset, irq, chg_status and sig_valid are 0, ts16_ready is 1 and every stored value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ts16_valid | input | 1 | Timeslot-16 byte offered |
| ts16_ready | output | 1 | Byte can be accepted |
| ts16_frame | input | 4 | Frame index of the byte within the multiframe |
| ts16_byte | input | 8 | Received timeslot-16 byte |
| sig_valid | output | 1 | Serial-side beat present |
| sig_ready | input | 1 | Serial side accepts the beat |
| sig_frame | output | 4 | Frame index of the forwarded byte |
| sig_byte | output | 8 | Forwarded signaling byte |
| frame_tick | input | 1 | One-cycle pulse every 125 µs frame |
| hold_sel | input | 2 | Hold-off period select |
| clear_chan | input | 30 | Per-channel clear-channel flags, bit i-1 for channel i |
| irq_mask | input | 1 | 1 blocks irq |
| status_rd | input | 1 | Status read pulse: clears status, restarts timer |
| rd_chan | input | 5 | Channel number 1..30 to read |
| rd_abcd | output | 4 | Stored ABCD value of rd_chan (0 if out of range) |
| chg_status | output | 1 | Merged signaling-change status |
| irq | output | 1 | Interrupt request |

## Verification
The bench attacks the nibble split and the frame-0 gap. A design that swapped nibbles or was off by one in the channel offset would place values in the wrong channel, and one that treated frame 0 as data would emit a stray beat. It counts ticks to the exact boundary for each hold-off setting, including the reserved code, so a timer one tick early or late, or one that mis-decodes code 11, flips status on the wrong side of the edge. It fires several changes inside one period and a change while status is already set: a design without rate limiting would raise status twice, and one that dropped the late change would never raise it again. It also checks that pre-alignment data, clear channels and a masked interrupt behave correctly, and that a stalled output holds its beat and blocks the input.

// File: rtl/cas_sig_pkg.sv
package cas_sig_pkg;
  localparam int NUM_CH   = 30;
  localparam int HALF_CH  = NUM_CH / 2;
  localparam int NIB_W    = 4;
  localparam int FIDX_W   = 4;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int CH_W     = $clog2(NUM_CH + 1);

  typedef logic [NIB_W-1:0] abcd_t;

  typedef enum logic [1:0] {
    HOLD_SHORT = 2'b00,
    HOLD_MID   = 2'b01,
    HOLD_LONG  = 2'b10,
    HOLD_RSVD  = 2'b11
  } hold_sel_e;
endpackage

// File: rtl/cas_ts16_extract.sv
module cas_ts16_extract
  import cas_sig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FIDX_W-1:0] in_frame,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FIDX_W-1:0] out_frame,
  output logic [BYTE_W-1:0] out_byte,
  output logic              acc,
  output logic              acc_data
);
  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign acc_data = acc && (in_frame != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_frame <= '0;
      out_byte  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (acc_data) begin
        out_valid <= 1'b1;
        out_frame <= in_frame;
        out_byte  <= in_byte;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_frame)); // R3
  AST_NO_FRAME0_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_frame != '0); // R1
endmodule

// File: rtl/cas_abcd_store.sv
module cas_abcd_store
  import cas_sig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_data,
  input  logic [FIDX_W-1:0] frame,
  input  logic [BYTE_W-1:0] data,
  input  logic [NUM_CH-1:0] clear_chan,
  input  logic [CH_W-1:0]   rd_chan,
  output abcd_t             rd_abcd,
  output logic              chg_hit
);
  localparam int IW = $clog2(NUM_CH);

  abcd_t             mem [NUM_CH];
  logic [NUM_CH-1:0] diff;
  logic [IW-1:0]     hi_idx, lo_idx;
  abcd_t             hi_nib, lo_nib;
  logic              loading, primed;

  assign hi_idx = IW'(frame) - IW'(1);
  assign lo_idx = IW'(frame) + IW'(HALF_CH - 1);
  assign hi_nib = data[BYTE_W-1:NIB_W];
  assign lo_nib = data[NIB_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic  hit_hi, hit_lo;
    abcd_t nxt;
    assign hit_hi = acc_data && (hi_idx == IW'(g));
    assign hit_lo = acc_data && (lo_idx == IW'(g));
    assign nxt    = hit_hi ? hi_nib : lo_nib;
    assign diff[g] = (hit_hi || hit_lo) && (nxt != mem[g]) && !clear_chan[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mem[g] <= '0;
      else if (hit_hi || hit_lo) mem[g] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b0;
      primed  <= 1'b0;
      chg_hit <= 1'b0;
    end else begin
      chg_hit <= primed && (|diff);
      if (acc && frame == '0 && !primed) loading <= 1'b1;
      if (acc && loading && frame == FIDX_W'(HALF_CH)) primed <= 1'b1;
    end
  end

  always_comb begin
    rd_abcd = '0;
    if (rd_chan >= CH_W'(1) && rd_chan <= CH_W'(NUM_CH))
      rd_abcd = mem[IW'(rd_chan - CH_W'(1))];
  end

  AST_NO_FLAG_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !chg_hit); // R4
  AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_hit |-> $past(acc_data)); // R5
endmodule

// File: rtl/cas_holdoff_timer.sv
module cas_holdoff_timer
  import cas_sig_pkg::*;
#(
  parameter int TICKS_PER_MS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       expired
);
  localparam int LIM_S = 2  * TICKS_PER_MS;
  localparam int LIM_M = 8  * TICKS_PER_MS;
  localparam int LIM_L = 16 * TICKS_PER_MS;
  localparam int CW    = $clog2(LIM_L + 1);

  hold_sel_e     mode;
  logic [CW-1:0] lim_m1, cnt;

  assign mode = hold_sel_e'(sel);

  always_comb begin
    case (mode)
      HOLD_SHORT: lim_m1 = CW'(LIM_S - 1);
      HOLD_MID:   lim_m1 = CW'(LIM_M - 1);
      default:    lim_m1 = CW'(LIM_L - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (cnt >= lim_m1) begin
        expired <= 1'b1;
        cnt     <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !restart |=> expired); // R7
  AST_EXP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick)); // R7
endmodule

// File: rtl/cas_sig_monitor.sv
module cas_sig_monitor
  import cas_sig_pkg::*;
#(
  parameter int TICKS_PER_MS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts16_valid,
  output logic              ts16_ready,
  input  logic [FIDX_W-1:0] ts16_frame,
  input  logic [BYTE_W-1:0] ts16_byte,
  output logic              sig_valid,
  input  logic              sig_ready,
  output logic [FIDX_W-1:0] sig_frame,
  output logic [BYTE_W-1:0] sig_byte,
  input  logic              frame_tick,
  input  logic [1:0]        hold_sel,
  input  logic [NUM_CH-1:0] clear_chan,
  input  logic              irq_mask,
  input  logic              status_rd,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [NIB_W-1:0]  rd_abcd,
  output logic              chg_status,
  output logic              irq
);
  logic acc, acc_data, chg_hit, tmr_expired, pend, promote;

  cas_ts16_extract u_extract (
    .clk(clk), .rst_n(rst_n),
    .in_valid(ts16_valid), .in_ready(ts16_ready),
    .in_frame(ts16_frame), .in_byte(ts16_byte),
    .out_valid(sig_valid), .out_ready(sig_ready),
    .out_frame(sig_frame), .out_byte(sig_byte),
    .acc(acc), .acc_data(acc_data)
  );

  cas_abcd_store u_store (
    .clk(clk), .rst_n(rst_n),
    .acc(acc), .acc_data(acc_data),
    .frame(ts16_frame), .data(ts16_byte),
    .clear_chan(clear_chan),
    .rd_chan(rd_chan), .rd_abcd(rd_abcd),
    .chg_hit(chg_hit)
  );

  cas_holdoff_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .tick(frame_tick), .sel(hold_sel),
    .restart(status_rd), .expired(tmr_expired)
  );

  assign promote = pend && tmr_expired && !chg_status && !status_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      chg_status <= 1'b0;
    end else begin
      pend <= (pend && !promote) || chg_hit;
      if (status_rd)    chg_status <= 1'b0;
      else if (promote) chg_status <= 1'b1;
    end
  end

  assign irq = chg_status && !irq_mask;

  AST_STATUS_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_status) |-> $past(tmr_expired) && $past(pend)); // R7
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    chg_status && !status_rd |=> chg_status); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !chg_status); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> chg_status); // R9
endmodule

// File: tb/cas_sig_monitor_tb.sv
module cas_sig_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts16_valid = 1'b0;
  logic        ts16_ready;
  logic [3:0]  ts16_frame = '0;
  logic [7:0]  ts16_byte = '0;
  logic        sig_valid;
  logic        sig_ready = 1'b1;
  logic [3:0]  sig_frame;
  logic [7:0]  sig_byte;
  logic        frame_tick = 1'b0;
  logic [1:0]  hold_sel = 2'b00;
  logic [29:0] clear_chan = '0;
  logic        irq_mask = 1'b0;
  logic        status_rd = 1'b0;
  logic [4:0]  rd_chan = '0;
  logic [3:0]  rd_abcd;
  logic        chg_status;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [3:0] mdl [1:30];

  // {frame, byte, expect an output beat}
  localparam logic [12:0] MF_TAB [16] = '{
    {4'd0,  8'h0F, 1'b0}, {4'd1,  8'h1E, 1'b1}, {4'd2,  8'h2D, 1'b1}, {4'd3,  8'h3C, 1'b1},
    {4'd4,  8'h4B, 1'b1}, {4'd5,  8'h5A, 1'b1}, {4'd6,  8'h69, 1'b1}, {4'd7,  8'h78, 1'b1},
    {4'd8,  8'h87, 1'b1}, {4'd9,  8'h96, 1'b1}, {4'd10, 8'hA5, 1'b1}, {4'd11, 8'hB4, 1'b1},
    {4'd12, 8'hC3, 1'b1}, {4'd13, 8'hD2, 1'b1}, {4'd14, 8'hE1, 1'b1}, {4'd15, 8'hF0, 1'b1}
  };

  cas_sig_monitor u_dut (
    .clk(clk), .rst_n(rst_n),
    .ts16_valid(ts16_valid), .ts16_ready(ts16_ready),
    .ts16_frame(ts16_frame), .ts16_byte(ts16_byte),
    .sig_valid(sig_valid), .sig_ready(sig_ready),
    .sig_frame(sig_frame), .sig_byte(sig_byte),
    .frame_tick(frame_tick), .hold_sel(hold_sel),
    .clear_chan(clear_chan), .irq_mask(irq_mask),
    .status_rd(status_rd), .rd_chan(rd_chan), .rd_abcd(rd_abcd),
    .chg_status(chg_status), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] f, input logic [7:0] d);
    while (!ts16_ready) @(negedge clk);
    ts16_valid = 1'b1; ts16_frame = f; ts16_byte = d;
    @(negedge clk);
    ts16_valid = 1'b0;
    if (f != 0) begin
      mdl[f] = d[7:4];
      mdl[f + 15] = d[3:0];
    end
  endtask

  task automatic rdchk(input string req, input int ch);
    rd_chan = 5'(ch);
    #1;
    check(req, rd_abcd, mdl[ch]);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic rd_status();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
  endtask

  task automatic period_edge(input string req, input int lim, input logic [3:0] f, input logic [7:0] d);
    rd_status();
    send(f, d);
    wait_clk(4);
    tick(lim - 1); wait_clk(3);
    check({req, " one tick short"}, chg_status, 1'b0);
    tick(1); wait_clk(3);
    check({req, " at limit"}, chg_status, 1'b1);
    rd_status();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 1; i <= 30; i++) mdl[i] = '0;
    wait_clk(3);
    // R10: reset state
    check("R10 irq", irq, 1'b0);
    check("R10 status", chg_status, 1'b0);
    check("R10 sig_valid", sig_valid, 1'b0);
    check("R10 ts16_ready", ts16_ready, 1'b1);
    rdchk("R10 store ch17", 17);
    @(negedge clk) rst_n = 1'b1;
    wait_clk(1);

    // R4: data ahead of alignment is stored, not flagged
    send(4'd3, 8'h5A);
    check("R2 pre-align beat", sig_byte, 8'h5A);
    rdchk("R4 pre-align ch3", 3);
    rdchk("R4 pre-align ch18", 18);

    // R1/R2: walk the multiframe table
    for (int k = 0; k < 16; k++) begin
      send(MF_TAB[k][12:9], MF_TAB[k][8:1]);
      check("R1 beat present", sig_valid, MF_TAB[k][0]);
      if (MF_TAB[k][0]) begin
        check("R2 beat frame", sig_frame, MF_TAB[k][12:9]);
        check("R2 beat byte", sig_byte, MF_TAB[k][8:1]);
        rdchk("R1 first nibble", int'(MF_TAB[k][12:9]));
        rdchk("R1 second nibble", int'(MF_TAB[k][12:9]) + 15);
      end
    end

    // R4: first multiframe flagged nothing even though ch3 changed
    tick(20); wait_clk(3);
    check("R4 no flag from first multiframe", chg_status, 1'b0);

    // R5: equal value -> nothing, different -> status
    send(4'd2, 8'h2D); wait_clk(4);
    check("R5 equal value", chg_status, 1'b0);
    send(4'd2, 8'h7D); wait_clk(4);
    check("R5 change status", chg_status, 1'b1);
    check("R9 irq unmasked", irq, 1'b1);

    // R8: change while status set, read, then next full period
    send(4'd4, 8'h9B); wait_clk(4);
    check("R8 still single", chg_status, 1'b1);
    rd_status(); wait_clk(2);
    check("R8 read clears", chg_status, 1'b0);
    tick(15); wait_clk(3);
    check("R8 held until period end", chg_status, 1'b0);
    tick(1); wait_clk(3);
    check("R8 late change surfaces", chg_status, 1'b1);
    rd_status(); tick(16); wait_clk(3);
    check("R8 nothing left pending", chg_status, 1'b0);

    // R8/R7: several changes inside one period -> one status
    rd_status();
    send(4'd6, 8'h19);
    send(4'd9, 8'h36);
    wait_clk(4);
    check("R7 waits for timer", chg_status, 1'b0);
    tick(16); wait_clk(3);
    check("R8 merged changes", chg_status, 1'b1);
    rd_status(); tick(16); wait_clk(3);
    check("R8 merged gives only one", chg_status, 1'b0);

    // R9: mask
    irq_mask = 1'b1;
    send(4'd10, 8'h55); wait_clk(4);
    check("R9 status under mask", chg_status, 1'b1);
    check("R9 irq masked", irq, 1'b0);
    irq_mask = 1'b0; #1;
    check("R9 irq after unmask", irq, 1'b1);
    @(negedge clk); rd_status();

    // R6: clear channel 20 (bit 19, second nibble of frame 5)
    clear_chan[19] = 1'b1;
    send(4'd5, 8'h53);
    tick(16); wait_clk(3);
    check("R6 clear channel ignored", chg_status, 1'b0);
    rdchk("R6 clear channel stored", 20);
    check("R6 clear channel forwarded", sig_byte, 8'h53);
    @(negedge clk);
    send(4'd5, 8'h83); wait_clk(4);
    check("R6 other channel still flags", chg_status, 1'b1);
    clear_chan = '0;

    // R7: period per select code
    hold_sel = 2'b01; period_edge("R7 sel01 64", 64, 4'd11, 8'h01);
    hold_sel = 2'b10; period_edge("R7 sel10 128", 128, 4'd12, 8'h02);
    hold_sel = 2'b11; period_edge("R7 sel11 128", 128, 4'd13, 8'h03);

    // R3: back-pressure
    sig_ready = 1'b0;
    wait_clk(2);
    send(4'd7, 8'h99);
    check("R3 ready low in stall", ts16_ready, 1'b0);
    ts16_valid = 1'b1; ts16_frame = 4'd8; ts16_byte = 8'hCC;
    wait_clk(3);
    check("R3 beat held valid", sig_valid, 1'b1);
    check("R3 beat held byte", sig_byte, 8'h99);
    check("R3 beat held frame", sig_frame, 4'd7);
    rdchk("R3 stalled byte not taken", 8);
    sig_ready = 1'b1;
    @(negedge clk);
    ts16_valid = 1'b0;
    mdl[8] = 4'hC; mdl[23] = 4'hC;
    check("R3 next beat after release", sig_byte, 8'hCC);
    rdchk("R3 stored after release", 23);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule